// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the control and status register file of a multi-channel memory-access layer that serves a set of transmit and a set of receive DMA channels. A processor reaches it over a simple device-control-register bus: one request strobe with a write flag, a 10-bit register address and 32-bit write data. Read data comes back registered, one cycle after the request, together with a valid pulse. The block keeps the global configuration, the error status and the interrupt enables. It also keeps the channel-active set and reset words for each direction, the end-of-buffer and descriptor-error status words, and a window of per-channel registers: table pointers for both directions and buffer sizes for receive. The number of channels in each window is set by a parameter.

The descriptor-fetch engine reports events on one-cycle strobe inputs, one strobe per channel and per kind. These strobes set bits in the status words. Software clears those bits by writing ones. Four level interrupt outputs summarise the status words, and each output is gated by its own enable bit. A configuration write with its top bit set performs a soft reset of the status, enable and channel-active state. The per-channel pointers and sizes survive the soft reset.

Top module: `dma_ctl_regfile`

## Requirements
- R1: After a synchronous active-low reset the configuration word reads 0x0007C000, every other register and every per-channel register reads zero, and all four interrupt outputs are low.
- R2: A read request returns the addressed register on `bus_rdata` with `bus_rvalid` high in the cycle after the request. A write request never raises `bus_rvalid`.
- R3: Register addresses are: configuration 0x180, error status 0x181, interrupt enable 0x182, transmit active-set 0x184, transmit active-reset 0x185, transmit end-of-buffer status 0x186, transmit descriptor-error status 0x187, and receive at 0x190 to 0x193 in the same order. Writes keep only these bits: configuration 0x00FFC087, interrupt enable 0x0000001F, transmit active words 0xF0000000, receive active words 0xC0000000.
- R4: Transmit table pointer i is at 0x1A0+i for i < TX_CHANS. Receive table pointer i is at 0x1C0+i and receive buffer size i is at 0x1E0+i, both for i < RX_CHANS. Pointers store all 32 bits and sizes store only bits 7:0. An address in a window at or beyond the channel count reads zero, and writes to it change nothing.
- R5: A read of any address that maps to no register returns zero.
- R6: An event strobe for channel i sets bit (31-i) of the matching status word. Bit k of `err_evt` sets bit k of the error status word.
- R7: A write to the error status word or to any of the four end-of-buffer and descriptor-error words clears exactly the bits written as one. All other bits are unchanged.
- R8: When an event strobe and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Interrupt enable bit 0 gates `irq_sys_err` (error status nonzero). Bit 1 gates `irq_tx_eob` (OR of the transmit end-of-buffer word). Bit 2 gates `irq_rx_eob` (OR of the receive end-of-buffer word). Bit 3 gates `irq_desc_err` (OR of both descriptor-error words). Bit 4 is stored and gates nothing.
- R10: A configuration write with bit 31 set clears the error status, the interrupt enable, all four channel-active words and all four end-of-buffer and descriptor-error words. Event strobes in the same cycle are dropped. The configuration word then takes the masked written value. Table pointers and buffer sizes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| tx_eob_evt | input | TX_CHANS | Transmit end-of-buffer event per channel |
| tx_derr_evt | input | TX_CHANS | Transmit descriptor-error event per channel |
| rx_eob_evt | input | RX_CHANS | Receive end-of-buffer event per channel |
| rx_derr_evt | input | RX_CHANS | Receive descriptor-error event per channel |
| err_evt | input | 32 | Error status set strobes, one per bit |
| irq_tx_eob | output | 1 | Transmit end-of-buffer interrupt |
| irq_rx_eob | output | 1 | Receive end-of-buffer interrupt |
| irq_desc_err | output | 1 | Descriptor-error interrupt |
| irq_sys_err | output | 1 | System error interrupt |

## Verification
The hardest situations to reach are the same-cycle collisions. One is an event strobe landing on a bit that a write-one-to-clear removes in that same cycle. The other is an event strobe arriving together with a soft-reset configuration write. The bench drives the bus write and the event strobe from one task on the same falling edge, so both reach the same rising edge. It then reads the status word back to see which source won. The survival of the per-channel windows across a soft reset is shown by filling pointers and sizes first and reading them back after the reset write.

// File: rtl/dmac_pkg.sv
// Package: shared constants of the DMA channel control register file.
// Assumes a 10-bit register address and 32-bit data on the control bus.
package dmac_pkg;
    localparam int DW = 32;
    localparam int AW = 10;

    localparam logic [AW-1:0] A_CFG     = 10'h180;
    localparam logic [AW-1:0] A_ERR     = 10'h181;
    localparam logic [AW-1:0] A_IEN     = 10'h182;
    localparam logic [AW-1:0] A_TX_ASET = 10'h184;
    localparam logic [AW-1:0] A_TX_ARST = 10'h185;
    localparam logic [AW-1:0] A_TX_EOB  = 10'h186;
    localparam logic [AW-1:0] A_TX_DERR = 10'h187;
    localparam logic [AW-1:0] A_RX_ASET = 10'h190;
    localparam logic [AW-1:0] A_RX_ARST = 10'h191;
    localparam logic [AW-1:0] A_RX_EOB  = 10'h192;
    localparam logic [AW-1:0] A_RX_DERR = 10'h193;

    // Window bases; each is aligned to 32 registers
    localparam logic [AW-1:0] A_TX_PTR  = 10'h1A0;
    localparam logic [AW-1:0] A_RX_PTR  = 10'h1C0;
    localparam logic [AW-1:0] A_RX_SIZE = 10'h1E0;

    localparam logic [DW-1:0] M_CFG    = 32'h00FF_C087;
    localparam logic [DW-1:0] M_IEN    = 32'h0000_001F;
    localparam logic [DW-1:0] M_TX_ACT = 32'hF000_0000;
    localparam logic [DW-1:0] M_RX_ACT = 32'hC000_0000;
    localparam logic [DW-1:0] M_SIZE   = 32'h0000_00FF;
    localparam logic [DW-1:0] M_PTR    = 32'hFFFF_FFFF;

    localparam logic [DW-1:0] CFG_RST  = 32'h0007_C000;
    localparam int            SOFT_BIT = 31;

    // Interrupt-enable bit positions
    localparam int IE_SYS  = 0;
    localparam int IE_TXEB = 1;
    localparam int IE_RXEB = 2;
    localparam int IE_DERR = 3;
endpackage

// File: rtl/dmac_status_bank.sv
// Module: one status word whose bits are set by hardware strobes and cleared
// by writing ones. Precedence: soft clear first, then set, then write-one-clear.
// Assumes set_vec is a one-cycle strobe vector already aligned to the word.
module dmac_status_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_eff;

    // Bits removed by the current write, if any
    always_comb clr_eff = clr_we ? clr_mask : '0;

    // Status word update with set-over-clear precedence
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (soft_clr) q <= '0;
        else               q <= (q & ~clr_eff) | set_vec;
    end

    // R8: a strobed bit is set in the next cycle even if written as one
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && set_vec != '0) |=> ((q & $past(set_vec)) == $past(set_vec)));

    // R7: a bit written as one and not strobed is clear in the next cycle
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !soft_clr) |=> ((q & $past(clr_mask & ~set_vec)) == '0));

    // R10: soft clear empties the word
    p_soft_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (q == '0));
endmodule

// File: rtl/dmac_chan_window.sv
// Module: a window of N per-channel registers with a keep mask on writes.
// Assumes the window base is 32-aligned so idx is the low 5 address bits;
// indices at or beyond N read zero and ignore writes.
module dmac_chan_window
    import dmac_pkg::*;
#(
    parameter int            N    = 4,
    parameter logic [DW-1:0] KEEP = M_PTR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          we,
    input  logic [4:0]    idx,
    input  logic [DW-1:0] wdata,
    output logic          hit,
    output logic [DW-1:0] rdata
);
    localparam int IW = 6;

    logic [DW-1:0] q [N];

    // Address falls inside the populated part of the window
    always_comb hit = sel && ({1'b0, idx} < IW'(N));

    // Read mux over the populated channels
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (hit && idx == 5'(i)) rdata = q[i];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chan
        // Per-channel register store; hard reset only
        always_ff @(posedge clk) begin
            if (!rst_n)                          q[g] <= '0;
            else if (hit && we && idx == 5'(g))  q[g] <= wdata & KEEP;
        end

        // R4: a write to channel g is visible in the next cycle, masked
        p_win_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && we && idx == 5'(g)) |=> (q[g] == $past(wdata & KEEP)));
    end
endmodule

// File: rtl/dma_ctl_regfile.sv
// Module: control/status register file of a multi-channel DMA access layer.
// Holds configuration, enables, channel-active words, five event status
// words and per-channel pointer/size windows; drives four gated interrupts.
// Assumes TX_CHANS <= 32 and RX_CHANS <= 32; channel i maps to bit 31-i.
module dma_ctl_regfile
    import dmac_pkg::*;
#(
    parameter int TX_CHANS = 4,
    parameter int RX_CHANS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                bus_rvalid,
    input  logic [TX_CHANS-1:0] tx_eob_evt,
    input  logic [TX_CHANS-1:0] tx_derr_evt,
    input  logic [RX_CHANS-1:0] rx_eob_evt,
    input  logic [RX_CHANS-1:0] rx_derr_evt,
    input  logic [DW-1:0]       err_evt,
    output logic                irq_tx_eob,
    output logic                irq_rx_eob,
    output logic                irq_desc_err,
    output logic                irq_sys_err
);
    localparam int WIN_LSB = 5;

    logic          wr, rd, soft_clr;
    logic [DW-1:0] cfg_q, ien_q, tx_aset_q, tx_arst_q, rx_aset_q, rx_arst_q;
    logic [DW-1:0] err_q, tx_eob_q, tx_derr_q, rx_eob_q, rx_derr_q;
    logic [DW-1:0] tx_eob_set, tx_derr_set, rx_eob_set, rx_derr_set;
    logic          sel_txp, sel_rxp, sel_rxs;
    logic          hit_txp, hit_rxp, hit_rxs;
    logic [DW-1:0] rd_txp, rd_rxp, rd_rxs, rd_mux;

    // Bus strobes and the soft-reset trigger
    always_comb begin
        wr       = bus_req && bus_we;
        rd       = bus_req && !bus_we;
        soft_clr = wr && bus_addr == A_CFG && bus_wdata[SOFT_BIT];
    end

    // Map channel strobes onto status bits, channel i at bit 31-i
    always_comb begin
        tx_eob_set  = '0;
        tx_derr_set = '0;
        rx_eob_set  = '0;
        rx_derr_set = '0;
        for (int i = 0; i < TX_CHANS; i++) begin
            tx_eob_set[DW-1-i]  = tx_eob_evt[i];
            tx_derr_set[DW-1-i] = tx_derr_evt[i];
        end
        for (int i = 0; i < RX_CHANS; i++) begin
            rx_eob_set[DW-1-i]  = rx_eob_evt[i];
            rx_derr_set[DW-1-i] = rx_derr_evt[i];
        end
    end

    // Plain masked registers: configuration, enables, active words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= CFG_RST;
            ien_q     <= '0;
            tx_aset_q <= '0;
            tx_arst_q <= '0;
            rx_aset_q <= '0;
            rx_arst_q <= '0;
        end else begin
            if (soft_clr) begin
                ien_q     <= '0;
                tx_aset_q <= '0;
                tx_arst_q <= '0;
                rx_aset_q <= '0;
                rx_arst_q <= '0;
            end
            if (wr) begin
                case (bus_addr)
                    A_CFG:     cfg_q     <= bus_wdata & M_CFG;
                    A_IEN:     ien_q     <= bus_wdata & M_IEN;
                    A_TX_ASET: tx_aset_q <= bus_wdata & M_TX_ACT;
                    A_TX_ARST: tx_arst_q <= bus_wdata & M_TX_ACT;
                    A_RX_ASET: rx_aset_q <= bus_wdata & M_RX_ACT;
                    A_RX_ARST: rx_arst_q <= bus_wdata & M_RX_ACT;
                    default: ;
                endcase
            end
        end
    end

    dmac_status_bank #(.W(DW)) u_err (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .clr_we(wr && bus_addr == A_ERR), .clr_mask(bus_wdata),
        .set_vec(err_evt), .q(err_q));
    dmac_status_bank #(.W(DW)) u_tx_eob (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .clr_we(wr && bus_addr == A_TX_EOB), .clr_mask(bus_wdata),
        .set_vec(tx_eob_set), .q(tx_eob_q));
    dmac_status_bank #(.W(DW)) u_tx_derr (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .clr_we(wr && bus_addr == A_TX_DERR), .clr_mask(bus_wdata),
        .set_vec(tx_derr_set), .q(tx_derr_q));
    dmac_status_bank #(.W(DW)) u_rx_eob (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .clr_we(wr && bus_addr == A_RX_EOB), .clr_mask(bus_wdata),
        .set_vec(rx_eob_set), .q(rx_eob_q));
    dmac_status_bank #(.W(DW)) u_rx_derr (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .clr_we(wr && bus_addr == A_RX_DERR), .clr_mask(bus_wdata),
        .set_vec(rx_derr_set), .q(rx_derr_q));

    // Window selects from the upper address bits
    always_comb begin
        sel_txp = bus_req && bus_addr[AW-1:WIN_LSB] == A_TX_PTR[AW-1:WIN_LSB];
        sel_rxp = bus_req && bus_addr[AW-1:WIN_LSB] == A_RX_PTR[AW-1:WIN_LSB];
        sel_rxs = bus_req && bus_addr[AW-1:WIN_LSB] == A_RX_SIZE[AW-1:WIN_LSB];
    end

    dmac_chan_window #(.N(TX_CHANS), .KEEP(M_PTR)) u_tx_ptr (
        .clk(clk), .rst_n(rst_n), .sel(sel_txp), .we(bus_we),
        .idx(bus_addr[WIN_LSB-1:0]), .wdata(bus_wdata),
        .hit(hit_txp), .rdata(rd_txp));
    dmac_chan_window #(.N(RX_CHANS), .KEEP(M_PTR)) u_rx_ptr (
        .clk(clk), .rst_n(rst_n), .sel(sel_rxp), .we(bus_we),
        .idx(bus_addr[WIN_LSB-1:0]), .wdata(bus_wdata),
        .hit(hit_rxp), .rdata(rd_rxp));
    dmac_chan_window #(.N(RX_CHANS), .KEEP(M_SIZE)) u_rx_size (
        .clk(clk), .rst_n(rst_n), .sel(sel_rxs), .we(bus_we),
        .idx(bus_addr[WIN_LSB-1:0]), .wdata(bus_wdata),
        .hit(hit_rxs), .rdata(rd_rxs));

    // Read mux; unmapped addresses give zero
    always_comb begin
        case (bus_addr)
            A_CFG:     rd_mux = cfg_q;
            A_ERR:     rd_mux = err_q;
            A_IEN:     rd_mux = ien_q;
            A_TX_ASET: rd_mux = tx_aset_q;
            A_TX_ARST: rd_mux = tx_arst_q;
            A_TX_EOB:  rd_mux = tx_eob_q;
            A_TX_DERR: rd_mux = tx_derr_q;
            A_RX_ASET: rd_mux = rx_aset_q;
            A_RX_ARST: rd_mux = rx_arst_q;
            A_RX_EOB:  rd_mux = rx_eob_q;
            A_RX_DERR: rd_mux = rx_derr_q;
            default:   rd_mux = hit_txp ? rd_txp :
                                hit_rxp ? rd_rxp :
                                hit_rxs ? rd_rxs : '0;
        endcase
    end

    // Registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd;
            if (rd) bus_rdata <= rd_mux;
        end
    end

    // Gated interrupt levels
    always_comb begin
        irq_sys_err  = ien_q[IE_SYS]  && (err_q != '0);
        irq_tx_eob   = ien_q[IE_TXEB] && (tx_eob_q != '0);
        irq_rx_eob   = ien_q[IE_RXEB] && (rx_eob_q != '0);
        irq_desc_err = ien_q[IE_DERR] && ((tx_derr_q | rx_derr_q) != '0);
    end

    // R2: every read request is answered in the next cycle
    p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid);

    // R2: writes never produce read data
    p_no_rvalid_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd) |=> !bus_rvalid);

    // R10: soft reset leaves enables and active words cleared
    p_soft_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (ien_q == '0 && tx_aset_q == '0 && rx_aset_q == '0));

    // R9: no interrupt while every enable is off
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !(irq_sys_err || irq_tx_eob || irq_rx_eob || irq_desc_err));
endmodule

// File: tb/dma_ctl_regfile_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for the DMA channel control register file. The read task
// pushes expected values; a monitor pops and compares on each rvalid.
module dma_ctl_regfile_tb_top;
    localparam int TXN = 4;
    localparam int RXN = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bus_req, bus_we;
    logic [9:0]      bus_addr;
    logic [31:0]     bus_wdata, bus_rdata;
    logic            bus_rvalid;
    logic [TXN-1:0]  tx_eob_evt, tx_derr_evt;
    logic [RXN-1:0]  rx_eob_evt, rx_derr_evt;
    logic [31:0]     err_evt;
    logic            irq_tx_eob, irq_rx_eob, irq_desc_err, irq_sys_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    dma_ctl_regfile #(.TX_CHANS(TXN), .RX_CHANS(RXN)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .tx_eob_evt(tx_eob_evt), .tx_derr_evt(tx_derr_evt),
        .rx_eob_evt(rx_eob_evt), .rx_derr_evt(rx_derr_evt),
        .err_evt(err_evt),
        .irq_tx_eob(irq_tx_eob), .irq_rx_eob(irq_rx_eob),
        .irq_desc_err(irq_desc_err), .irq_sys_err(irq_sys_err));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each returned read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected rvalid", 32'h1, 32'h0);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic idle_bus();
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        tx_eob_evt = '0; tx_derr_evt = '0; rx_eob_evt = '0; rx_derr_evt = '0;
        err_evt = '0;
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic rd(logic [9:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        idle_bus();
    endtask

    task automatic pulse(logic [TXN-1:0] te, logic [TXN-1:0] td,
                         logic [RXN-1:0] re, logic [RXN-1:0] rd_, logic [31:0] ee);
        @(negedge clk);
        tx_eob_evt = te; tx_derr_evt = td; rx_eob_evt = re; rx_derr_evt = rd_;
        err_evt = ee;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic chk_irq(string tag, logic [3:0] exp);
        chk(tag, {28'h0, irq_sys_err, irq_tx_eob, irq_rx_eob, irq_desc_err}, {28'h0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    // Stimulus; irq vector order is {sys, tx_eob, rx_eob, desc_err}
    initial begin
        rst_n = 1'b0;
        idle_bus();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk_irq("R1 irqs after reset", 4'b0000);
        rd(10'h180, 32'h0007_C000, "R1 cfg reset");
        rd(10'h182, 32'h0, "R1 ien reset");
        rd(10'h184, 32'h0, "R1 tx active-set reset");
        rd(10'h1A0, 32'h0, "R1 tx ptr reset");
        rd(10'h1E1, 32'h0, "R1 rx size reset");

        // R3 write masks
        wr(10'h182, 32'hFFFF_FFFF);
        rd(10'h182, 32'h0000_001F, "R3 ien mask");
        wr(10'h184, 32'hFFFF_FFFF);
        rd(10'h184, 32'hF000_0000, "R3 tx active-set mask");
        wr(10'h185, 32'h0FFF_FFFF);
        rd(10'h185, 32'h0, "R3 tx active-reset mask");
        wr(10'h190, 32'hFFFF_FFFF);
        rd(10'h190, 32'hC000_0000, "R3 rx active-set mask");
        wr(10'h180, 32'h7FFF_FFFF);
        rd(10'h180, 32'h00FF_C087, "R3 cfg mask");

        // R4 windows
        wr(10'h1A3, 32'hDEAD_BEEF);
        rd(10'h1A3, 32'hDEAD_BEEF, "R4 tx ptr 3");
        wr(10'h1C1, 32'h1234_5678);
        rd(10'h1C1, 32'h1234_5678, "R4 rx ptr 1");
        wr(10'h1E1, 32'h0000_ABCD);
        rd(10'h1E1, 32'h0000_00CD, "R4 rx size low byte");
        wr(10'h1A4, 32'h0000_0055);
        rd(10'h1A4, 32'h0, "R4 tx ptr beyond count");
        wr(10'h1C2, 32'h0000_0077);
        rd(10'h1C2, 32'h0, "R4 rx ptr beyond count");
        rd(10'h1E2, 32'h0, "R4 rx size beyond count");

        // R5 unmapped
        rd(10'h183, 32'h0, "R5 hole 0x183");
        rd(10'h1FF, 32'h0, "R5 hole 0x1FF");
        rd(10'h000, 32'h0, "R5 hole 0x000");

        // R6 events, R9 interrupts with all enables on
        pulse(4'b0010, 4'b0000, 2'b00, 2'b00, 32'h0);
        chk_irq("R9 tx eob irq", 4'b0100);
        rd(10'h186, 32'h4000_0000, "R6 tx eob ch1 bit30");
        pulse(4'b0000, 4'b0000, 2'b00, 2'b01, 32'h0);
        chk_irq("R9 desc err irq", 4'b0101);
        rd(10'h193, 32'h8000_0000, "R6 rx derr ch0 bit31");
        pulse(4'b0000, 4'b1000, 2'b00, 2'b00, 32'h0000_0005);
        chk_irq("R9 sys err irq", 4'b1101);
        rd(10'h181, 32'h0000_0005, "R6 err status");
        rd(10'h187, 32'h1000_0000, "R6 tx derr ch3 bit28");

        // R7 write-one-to-clear
        wr(10'h186, 32'h4000_0000);
        chk_irq("R7 tx eob irq drops", 4'b1001);
        rd(10'h186, 32'h0, "R7 tx eob cleared");
        wr(10'h181, 32'h0000_0001);
        rd(10'h181, 32'h0000_0004, "R7 err partial clear");
        wr(10'h187, 32'h0);
        rd(10'h187, 32'h1000_0000, "R7 zero write keeps");

        // R9 gating per enable bit
        wr(10'h182, 32'h0);
        chk_irq("R9 all gated", 4'b0000);
        wr(10'h182, 32'h0000_0008);
        chk_irq("R9 desc only", 4'b0001);
        wr(10'h182, 32'h0000_0001);
        chk_irq("R9 sys only", 4'b1000);
        wr(10'h182, 32'h0000_001F);

        // R8 set beats same-cycle clear
        pulse(4'b0000, 4'b0000, 2'b11, 2'b00, 32'h0);
        chk_irq("R9 rx eob irq", 4'b1011);
        rd(10'h192, 32'hC000_0000, "R6 rx eob both");
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'h192;
        bus_wdata = 32'hC000_0000; rx_eob_evt = 2'b01;
        @(negedge clk);
        idle_bus();
        rd(10'h192, 32'h8000_0000, "R8 set wins over clear");

        // R10 soft reset with a same-cycle event
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'h180;
        bus_wdata = 32'h8000_0000; tx_eob_evt = 4'b0001;
        @(negedge clk);
        idle_bus();
        chk_irq("R10 irqs after soft reset", 4'b0000);
        rd(10'h180, 32'h0, "R10 cfg masked value");
        rd(10'h182, 32'h0, "R10 ien cleared");
        rd(10'h184, 32'h0, "R10 tx active cleared");
        rd(10'h190, 32'h0, "R10 rx active cleared");
        rd(10'h181, 32'h0, "R10 err cleared");
        rd(10'h186, 32'h0, "R10 event dropped");
        rd(10'h187, 32'h0, "R10 tx derr cleared");
        rd(10'h192, 32'h0, "R10 rx eob cleared");
        rd(10'h193, 32'h0, "R10 rx derr cleared");
        rd(10'h1A3, 32'hDEAD_BEEF, "R10 tx ptr kept");
        rd(10'h1C1, 32'h1234_5678, "R10 rx ptr kept");
        rd(10'h1E1, 32'h0000_00CD, "R10 rx size kept");
        wr(10'h180, 32'h8000_C001);
        rd(10'h180, 32'h0000_C001, "R10 cfg after soft reset write");

        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule